// File: doc/BRIEF.md
# Multi-rate status LED blinker with pin override

The block drives a status LED from the system clock. A single 8-bit configuration register chooses one of three blink rates or a constant level, and names a pin on one of two GPIO ports that gives up its normal function to carry the LED signal. For each port the block puts out a one-hot override vector. The pad logic of that port uses it to disconnect the chosen pin from its input and output path and to connect the LED value instead. The LED override wins over whatever direction or output value the GPIO logic has set up for that pin.

Configuration byte layout: bit 7 is the enable. Bits 6..4 are the mode. Bit 3 selects the port (0 = port A, 1 = port B). Bits 2..0 are the pin index. One free-running prescaler counts `HALF_CYCLES` clocks to make a half-period tick for the fastest rate. A 3-bit phase counter divides that tick down for the two slower rates. A write that changes the mode field restarts both the prescaler and the phase counter. The pad type is fixed by the `OPEN_DRAIN` parameter and sets the drive-enable output.

Top module: `led_blink_ovr`

## Requirements
- R1: After reset the register holds 0x00. Both override vectors are zero, `led_val` is 0 and `led_oe` is 1.
- R2: While bit 7 is 0, both override vectors are zero, whatever the port and pin fields hold.
- R3: With bit 7 = 1 and bit 3 = 0, pin codes 0..6 set only bit `pin` of `pa_ovr`, and `pb_ovr` stays zero. Pin code 7 overrides no pin. At no time is more than one pin overridden across both ports.
- R4: With bit 7 = 1 and bit 3 = 1, pin codes 3..5 set only bit `pin` of `pb_ovr`, and `pa_ovr` stays zero. Every other pin code overrides no pin.
- R5: Mode 110 gives a square wave of period 2·HALF_CYCLES clocks. `led_val` is high for the first HALF_CYCLES clocks after the write edge and low for the next HALF_CYCLES. Between ticks and writes, `led_val` does not change.
- R6: Mode 101 gives a square wave that is high for 2·HALF_CYCLES clocks and then low for 2·HALF_CYCLES clocks.
- R7: Mode 100 gives a square wave that is high for 4·HALF_CYCLES clocks and then low for 4·HALF_CYCLES clocks.
- R8: Mode 111 releases the pin. `led_val` is 1, and `led_oe` is 0 when OPEN_DRAIN = 1 or 1 when OPEN_DRAIN = 0.
- R9: Modes 000, 001, 010 and 011 drive low: `led_val` is 0 and `led_oe` is 1.
- R10: A write whose mode field differs from the stored one restarts the phase. From the write edge the waveform begins a fresh high half-period. `led_oe` is the inverse of `led_val` in every mode when OPEN_DRAIN = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration byte to store |
| pa_ovr | output | PA_PINS | One-hot override vector for port A |
| pb_ovr | output | PB_PINS | One-hot override vector for port B |
| led_val | output | 1 | LED logic value for the overridden pin |
| led_oe | output | 1 | Pad drive enable for the overridden pin |

## Verification
The bench builds the block with HALF_CYCLES = 3 and the default open-drain pad. With these values the longest waveform, the eight-tick period of mode 100, fits in a few dozen cycles. The bench can therefore follow every rate through complete periods, and through restarts in the middle of a period, cycle by cycle. The port widths stay at their defaults of 8 and 7. This brings every in-range pin code and every out-of-range pin code on both ports within reach of a single sweep.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  localparam int CFG_W  = 8;
  localparam int MODE_W = 3;
  localparam int PIN_W  = 3;
  localparam int PH_W   = 3;

  localparam logic [MODE_W-1:0] MODE_RELEASE = 3'b111;
  localparam logic [MODE_W-1:0] MODE_FAST    = 3'b110;
  localparam logic [MODE_W-1:0] MODE_MID     = 3'b101;
  localparam logic [MODE_W-1:0] MODE_SLOW    = 3'b100;

  typedef struct packed {
    logic              en;
    logic [MODE_W-1:0] mode;
    logic              port_b;
    logic [PIN_W-1:0]  pin;
  } led_cfg_t;

  function automatic logic mode_is_blink(input logic [MODE_W-1:0] m);
    return (m == MODE_FAST) || (m == MODE_MID) || (m == MODE_SLOW);
  endfunction

  // Phase bit k is the tick count divided by 2**k; the wave is high on the
  // even half of that division.
  function automatic logic mode_level(input logic [MODE_W-1:0] m,
                                      input logic [PH_W-1:0]   ph);
    logic lvl;
    case (m)
      MODE_RELEASE: lvl = 1'b1;
      MODE_FAST:    lvl = ~ph[0];
      MODE_MID:     lvl = ~ph[1];
      MODE_SLOW:    lvl = ~ph[2];
      default:      lvl = 1'b0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/led_cfg_reg.sv
module led_cfg_reg
  import led_blink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output led_cfg_t         cfg,
  output logic             restart
);

  led_cfg_t wcfg;
  assign wcfg = led_cfg_t'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (we) cfg <= wcfg;
  end

  assign restart = we && (wcfg.mode != cfg.mode);

endmodule

// File: rtl/led_rate_gen.sv
module led_rate_gen
  import led_blink_pkg::*;
#(
  parameter int HALF_CYCLES = 100_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  output logic            tick,
  output logic [PH_W-1:0] phase
);

  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= '0;
    end else if (restart) begin
      cnt   <= '0;
      phase <= '0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= phase + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/led_pin_steer.sv
module led_pin_steer
  import led_blink_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int LO     = 0,
  parameter int HI     = 6
) (
  input  logic              en,
  input  logic [PIN_W-1:0]  sel,
  output logic [N_PINS-1:0] ovr
);

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    if (i >= LO && i <= HI) begin : g_live
      assign ovr[i] = en && (sel == PIN_W'(i));
    end else begin : g_dead
      assign ovr[i] = 1'b0;
    end
  end

endmodule

// File: rtl/led_blink_ovr.sv
module led_blink_ovr
  import led_blink_pkg::*;
#(
  parameter int HALF_CYCLES = 100_000_000,
  parameter int PA_PINS     = 8,
  parameter int PB_PINS     = 7,
  parameter int PA_LO       = 0,
  parameter int PA_HI       = 6,
  parameter int PB_LO       = 3,
  parameter int PB_HI       = 5,
  parameter bit OPEN_DRAIN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [PA_PINS-1:0] pa_ovr,
  output logic [PB_PINS-1:0] pb_ovr,
  output logic               led_val,
  output logic               led_oe
);

  led_cfg_t          cfg;
  logic              restart;
  logic              tick;
  logic [PH_W-1:0]   phase;
  logic [MODE_W-1:0] cur_mode;
  logic              cur_en;

  assign cur_mode = cfg.mode;
  assign cur_en   = cfg.en;

  led_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata),
    .cfg     (cfg),
    .restart (restart)
  );

  led_rate_gen #(.HALF_CYCLES(HALF_CYCLES)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .phase   (phase)
  );

  led_pin_steer #(.N_PINS(PA_PINS), .LO(PA_LO), .HI(PA_HI)) u_steer_a (
    .en  (cfg.en && !cfg.port_b),
    .sel (cfg.pin),
    .ovr (pa_ovr)
  );

  led_pin_steer #(.N_PINS(PB_PINS), .LO(PB_LO), .HI(PB_HI)) u_steer_b (
    .en  (cfg.en && cfg.port_b),
    .sel (cfg.pin),
    .ovr (pb_ovr)
  );

  assign led_val = mode_level(cfg.mode, phase);

  if (OPEN_DRAIN) begin : g_od
    assign led_oe = ~led_val;
  end else begin : g_pp
    assign led_oe = 1'b1;
  end

endmodule

// File: rtl/led_blink_chk.sv
module led_blink_chk
  import led_blink_pkg::*;
#(
  parameter int PA_PINS    = 8,
  parameter int PB_PINS    = 7,
  parameter int PB_LO      = 3,
  parameter int PB_HI      = 5,
  parameter bit OPEN_DRAIN = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [CFG_W-1:0]   cfg_wdata,
  input logic [MODE_W-1:0]  cur_mode,
  input logic               cur_en,
  input logic               tick,
  input logic [PA_PINS-1:0] pa_ovr,
  input logic [PB_PINS-1:0] pb_ovr,
  input logic               led_val,
  input logic               led_oe
);

  function automatic logic [PB_PINS-1:0] pb_window();
    logic [PB_PINS-1:0] m;
    for (int i = 0; i < PB_PINS; i++) m[i] = (i >= PB_LO && i <= PB_HI);
    return m;
  endfunction

  localparam logic [PB_PINS-1:0] PB_MASK = pb_window();

  logic [MODE_W-1:0] wmode;
  assign wmode = cfg_wdata[6:4];

  AST_OFF_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |-> (pa_ovr == '0 && pb_ovr == '0)); // R2

  AST_ONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pa_ovr, pb_ovr}) <= 1); // R3

  AST_PB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_ovr & ~PB_MASK) == '0); // R4

  AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cfg_we) |=> $stable(led_val)); // R5

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_RELEASE) |-> (led_val && (led_oe == !OPEN_DRAIN))); // R8

  AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode[2] == 1'b0) |-> (!led_val && led_oe)); // R9

  AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && mode_is_blink(wmode) && wmode != cur_mode) |=> led_val); // R10

endmodule

bind led_blink_ovr led_blink_chk #(
  .PA_PINS(PA_PINS), .PB_PINS(PB_PINS), .PB_LO(PB_LO), .PB_HI(PB_HI),
  .OPEN_DRAIN(OPEN_DRAIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cur_mode(cur_mode), .cur_en(cur_en), .tick(tick),
  .pa_ovr(pa_ovr), .pb_ovr(pb_ovr), .led_val(led_val), .led_oe(led_oe)
);

// File: tb/led_blink_ovr_test.sv
module led_blink_ovr_test;

  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] pa_ovr;
  logic [6:0] pb_ovr;
  logic       led_val, led_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] pa;
    logic [6:0] pb;
    logic       val;
    logic       oe;
    string      req;
  } exp_t;

  exp_t sbq[$];

  always #2.5 clk = ~clk;

  led_blink_ovr #(.HALF_CYCLES(H)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pa_ovr(pa_ovr), .pb_ovr(pb_ovr), .led_val(led_val), .led_oe(led_oe)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (pa_ovr !== e.pa || pb_ovr !== e.pb || led_val !== e.val || led_oe !== e.oe) begin
      failures++;
      $display("FAIL %s: got pa=%h pb=%h val=%b oe=%b expected pa=%h pb=%h val=%b oe=%b",
               e.req, pa_ovr, pb_ovr, led_val, led_oe, e.pa, e.pb, e.val, e.oe);
    end
  endtask

  // Expected level i clocks after a restarting write.
  function automatic logic want_level(input logic [2:0] m, input int i);
    case (m)
      3'b111:  return 1'b1;
      3'b110:  return ((i / H) % 2) == 0;
      3'b101:  return ((i / (2 * H)) % 2) == 0;
      3'b100:  return ((i / (4 * H)) % 2) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic put(input logic [7:0] v, input int n, input string req);
    logic en; logic pb_sel; int pin;
    en = v[7]; pb_sel = v[3]; pin = int'(v[2:0]);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.pa = '0; e.pb = '0;
      if (en && !pb_sel && pin <= 6) e.pa = 8'(1 << pin);
      if (en && pb_sel && pin >= 3 && pin <= 5) e.pb = 7'(1 << pin);
      e.val = want_level(v[6:4], i);
      e.oe = !e.val;
      e.req = req;
      sbq.push_back(e);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    wait (sbq.size() == 0);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) compare(sbq.pop_front());
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    exp_t r;
    repeat (3) @(negedge clk);
    r.pa = '0; r.pb = '0; r.val = 1'b0; r.oe = 1'b1; r.req = "R1 reset";
    compare(r);
    rst_n = 1'b1;
    @(negedge clk);
    compare(r);

    put(8'h60, 4 * H, "R2 disabled 1Hz");
    put(8'h7D, 2, "R2 disabled release");
    for (int p = 0; p < 8; p++) begin
      put(8'h80 | 8'(p), 2, "R3 port A low");
      put(8'hF0 | 8'(p), 2, "R3 port A release");
    end
    for (int p = 0; p < 8; p++) begin
      put(8'h88 | 8'(p), 2, "R4 port B low");
      put(8'hF8 | 8'(p), 2, "R4 port B release");
    end
    put(8'hE5, 8 * H + 2, "R5 1Hz");
    put(8'hD5, 8 * H + 2, "R6 0.5Hz");
    put(8'hC5, 8 * H + 2, "R7 0.25Hz");
    put(8'hE5, H + 1, "R10 restart to 1Hz");
    put(8'hC2, 5 * H, "R10 restart mid-phase");
    put(8'hFC, 3, "R8 release");
    put(8'h9B, 2, "R9 code 001");
    put(8'hAB, 2, "R9 code 010");
    put(8'hBC, 2, "R9 code 011");
    put(8'hEC, 8 * H, "R5 1Hz on port B");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule